// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing protocol engine of a 4096-byte serial memory. It oversamples the serial clock and data lines on a fast system clock. It finds start and stop conditions and shifts in an 8-bit slave address. That address holds three select bits, the four upper bits of the array address, and a direction bit. When the select bits fit the strap pins, the engine pulls the data line low to acknowledge. It then moves bytes in either direction, one byte-level strobe at a time.

A memory controller sits behind the engine. It receives the address-accepted strobe with the upper address bits and the direction. In a write it receives every following byte, and the first of these is flagged so the controller can treat it as the low word address. In a read it keeps the next output byte on a data input, and the engine takes that byte at the start of each byte slot. A stop that ends an addressed transfer is reported so the controller can start its internal write cycle. While that cycle runs, the controller raises a busy input and the engine then acknowledges no address.

Top module: `twsm_slave`

## Requirements
- R1: During and after a synchronous reset, the data line is released (`sda_drv_n_o` = 1) and all strobes are low.
- R2: A falling data line while the clock is high is a start, and a rising data line while the clock is high is a stop. A stop that ends an addressed read or write pulses `stop_stb_o` for one cycle. At most one of the four strobes is high in any cycle.
- R3: Address bits arrive MSB first as [7] S2, [6] S1, [5] S0, [4:1] upper address, [0] direction (1 = read). The address matches only when S2 and S0 equal the inverted `dev_sel_i[2]` and `dev_sel_i[0]`, and S1 equals `dev_sel_i[1]`. On a match, `addr_hi_o` and `rw_o` show the received fields.
- R4: After a matching address, the engine holds the data line low through the ninth clock. `addr_stb_o` pulses in the same cycle that the low drive begins.
- R5: While `busy_i` is high, no address is acknowledged and `addr_stb_o` stays low.
- R6: In a write, every received byte is acknowledged and presented on `wr_byte_o` with a one-cycle `wr_stb_o`. `wr_first_o` is 1 only for the first byte after the address.
- R7: In a read, the engine takes `rd_data_i` with a one-cycle `rd_take_o` at the start of each byte and sends it MSB first. It moves on to the next byte only when the master pulls the ninth bit low.
- R8: After the master leaves the ninth bit of a read high, the engine releases the data line. It then ignores all clocks and data until the next start, and gives no stop strobe.
- R9: An address that does not match gets no acknowledge. The engine then ignores all further bytes until the next start, and gives no stop strobe.
- R10: A stop in the middle of a byte returns the engine to idle without presenting the partial byte, and later clocks get no response until a start. A start in the middle of a byte begins a fresh address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| dev_sel_i | input | 3 | Strap pins that select the device address |
| busy_i | input | 1 | Internal write cycle in progress |
| rd_data_i | input | 8 | Next byte to transmit in a read |
| sda_drv_n_o | output | 1 | Active-low pull-down enable for the data line |
| addr_stb_o | output | 1 | Matching address accepted |
| addr_hi_o | output | 4 | Upper array address bits from the slave address |
| rw_o | output | 1 | Direction of the accepted transfer (1 = read) |
| wr_stb_o | output | 1 | Write byte received |
| wr_first_o | output | 1 | Marks the first write byte after the address |
| wr_byte_o | output | 8 | Received write byte |
| rd_take_o | output | 1 | Read byte on `rd_data_i` taken into the shifter |
| stop_stb_o | output | 1 | Stop ended an addressed transfer |

## Verification
The assertions assume that the controller drops no byte and holds `busy_i` steady for whole bus phases. They also assume a master that changes data only while the clock is low, with each clock phase several system cycles long. The stimulus keeps to this by running each quarter bit for four system cycles. The master model changes its data output only in the middle of a low phase, and `busy_i` and the strap pins change only while the bus is idle. Random select values, directions, match or mismatch and byte counts are mixed with directed aborts placed partway through a byte.

// File: rtl/twsm_pkg.sv
`timescale 1ns/1ps
package twsm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_MACK,
    ST_IGNORE
  } twsm_state_e;

  // Registered line events from the oversampling monitor
  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } twsm_line_t;

endpackage

// File: rtl/twsm_line_mon.sv
`timescale 1ns/1ps
module twsm_line_mon
  import twsm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output twsm_line_t ev_o
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] now_v;
  logic [NLINES-1:0] prev_v;

  assign raw = {scl_i, sda_i};

  // One synchronizer chain per bus line
  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain     <= '1;
        prev_v[g] <= 1'b1;
      end else begin
        chain     <= {chain[SYNC_STAGES-2:0], raw[g]};
        prev_v[g] <= chain[SYNC_STAGES-1];
      end
    end
    assign now_v[g] = chain[SYNC_STAGES-1];
  end

  logic scl_s, sda_s, scl_q, sda_q;
  assign scl_s = now_v[1];
  assign sda_s = now_v[0];
  assign scl_q = prev_v[1];
  assign sda_q = prev_v[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_o <= '{scl_rise: 1'b0, scl_fall: 1'b0, start: 1'b0, stop: 1'b0, sda: 1'b1};
    end else begin
      ev_o.scl_rise <= scl_s & ~scl_q;
      ev_o.scl_fall <= ~scl_s & scl_q;
      ev_o.start    <= scl_s & scl_q & ~sda_s & sda_q;
      ev_o.stop     <= scl_s & scl_q & sda_s & ~sda_q;
      ev_o.sda      <= sda_s;
    end
  end

endmodule

// File: rtl/twsm_addr_match.sv
`timescale 1ns/1ps
module twsm_addr_match #(
  parameter int                  SEL_BITS     = 3,
  parameter logic [SEL_BITS-1:0] SEL_INV_MASK = 3'b101
) (
  input  logic [SEL_BITS-1:0] sel_field,
  input  logic [SEL_BITS-1:0] pins,
  output logic                hit
);

  logic [SEL_BITS-1:0] ok;

  // Each select bit compares either straight or inverted against its pin
  for (genvar g = 0; g < SEL_BITS; g++) begin : g_bit
    if (SEL_INV_MASK[g]) begin : g_inv
      assign ok[g] = (sel_field[g] == ~pins[g]);
    end else begin : g_dir
      assign ok[g] = (sel_field[g] == pins[g]);
    end
  end

  assign hit = &ok;

endmodule

// File: rtl/twsm_engine.sv
`timescale 1ns/1ps
module twsm_engine
  import twsm_pkg::*;
#(
  parameter int                  SEL_BITS     = 3,
  parameter int                  HI_BITS      = 4,
  parameter logic [SEL_BITS-1:0] SEL_INV_MASK = 3'b101
) (
  input  logic                            clk,
  input  logic                            rst,
  input  twsm_line_t                      ev,
  input  logic [SEL_BITS-1:0]             dev_sel_i,
  input  logic                            busy_i,
  input  logic [SEL_BITS+HI_BITS:0]       rd_data_i,
  output logic                            sda_drv_n_o,
  output logic                            addr_stb_o,
  output logic [HI_BITS-1:0]              addr_hi_o,
  output logic                            rw_o,
  output logic                            wr_stb_o,
  output logic                            wr_first_o,
  output logic [SEL_BITS+HI_BITS:0]       wr_byte_o,
  output logic                            rd_take_o,
  output logic                            stop_stb_o
);

  localparam int BYTE_W = SEL_BITS + HI_BITS + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  twsm_state_e         state;
  logic [BYTE_W-1:0]   shreg;
  logic [CNT_W-1:0]    bit_cnt;
  logic                first_pend;
  logic                mack;
  logic                hit;
  logic                selected;

  twsm_addr_match #(
    .SEL_BITS    (SEL_BITS),
    .SEL_INV_MASK(SEL_INV_MASK)
  ) u_match (
    .sel_field(shreg[BYTE_W-1 -: SEL_BITS]),
    .pins     (dev_sel_i),
    .hit      (hit)
  );

  always_comb begin
    selected = (state == ST_ADDR_ACK) || (state == ST_WR_BYTE) ||
               (state == ST_WR_ACK)   || (state == ST_RD_BYTE) ||
               (state == ST_RD_MACK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      shreg       <= '0;
      bit_cnt     <= '0;
      first_pend  <= 1'b0;
      mack        <= 1'b0;
      sda_drv_n_o <= 1'b1;
      addr_stb_o  <= 1'b0;
      addr_hi_o   <= '0;
      rw_o        <= 1'b0;
      wr_stb_o    <= 1'b0;
      wr_first_o  <= 1'b0;
      wr_byte_o   <= '0;
      rd_take_o   <= 1'b0;
      stop_stb_o  <= 1'b0;
    end else begin
      addr_stb_o <= 1'b0;
      wr_stb_o   <= 1'b0;
      rd_take_o  <= 1'b0;
      stop_stb_o <= 1'b0;

      if (ev.start) begin
        state       <= ST_ADDR;
        bit_cnt     <= '0;
        sda_drv_n_o <= 1'b1;
      end else if (ev.stop) begin
        stop_stb_o  <= selected;
        state       <= ST_IDLE;
        bit_cnt     <= '0;
        sda_drv_n_o <= 1'b1;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (ev.scl_rise && bit_cnt != FULL) begin
              shreg   <= {shreg[BYTE_W-2:0], ev.sda};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (ev.scl_fall && bit_cnt == FULL) begin
              if (hit && !busy_i) begin
                sda_drv_n_o <= 1'b0;
                addr_stb_o  <= 1'b1;
                addr_hi_o   <= shreg[1 +: HI_BITS];
                rw_o        <= shreg[0];
                state       <= ST_ADDR_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end

          ST_ADDR_ACK: begin
            if (ev.scl_fall) begin
              bit_cnt <= '0;
              if (rw_o) begin
                shreg       <= rd_data_i;
                sda_drv_n_o <= rd_data_i[BYTE_W-1];
                rd_take_o   <= 1'b1;
                state       <= ST_RD_BYTE;
              end else begin
                sda_drv_n_o <= 1'b1;
                first_pend  <= 1'b1;
                state       <= ST_WR_BYTE;
              end
            end
          end

          ST_WR_BYTE: begin
            if (ev.scl_rise && bit_cnt != FULL) begin
              shreg   <= {shreg[BYTE_W-2:0], ev.sda};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (ev.scl_fall && bit_cnt == FULL) begin
              sda_drv_n_o <= 1'b0;
              wr_stb_o    <= 1'b1;
              wr_byte_o   <= shreg;
              wr_first_o  <= first_pend;
              first_pend  <= 1'b0;
              state       <= ST_WR_ACK;
            end
          end

          ST_WR_ACK: begin
            if (ev.scl_fall) begin
              sda_drv_n_o <= 1'b1;
              bit_cnt     <= '0;
              state       <= ST_WR_BYTE;
            end
          end

          ST_RD_BYTE: begin
            if (ev.scl_rise && bit_cnt != FULL) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (ev.scl_fall) begin
              if (bit_cnt == FULL) begin
                sda_drv_n_o <= 1'b1;
                state       <= ST_RD_MACK;
              end else begin
                shreg       <= {shreg[BYTE_W-2:0], 1'b0};
                sda_drv_n_o <= shreg[BYTE_W-2];
              end
            end
          end

          ST_RD_MACK: begin
            if (ev.scl_rise) begin
              mack <= ~ev.sda;
            end else if (ev.scl_fall) begin
              bit_cnt <= '0;
              if (mack) begin
                shreg       <= rd_data_i;
                sda_drv_n_o <= rd_data_i[BYTE_W-1];
                rd_take_o   <= 1'b1;
                state       <= ST_RD_BYTE;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end

          default: begin
            // idle or ignoring: only a start leaves these states
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/twsm_slave.sv
`timescale 1ns/1ps
module twsm_slave
  import twsm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_BITS    = 3,
  parameter int HI_BITS     = 4,
  parameter logic [SEL_BITS-1:0] SEL_INV_MASK = 3'b101
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      scl_i,
  input  logic                      sda_i,
  input  logic [SEL_BITS-1:0]       dev_sel_i,
  input  logic                      busy_i,
  input  logic [SEL_BITS+HI_BITS:0] rd_data_i,
  output logic                      sda_drv_n_o,
  output logic                      addr_stb_o,
  output logic [HI_BITS-1:0]        addr_hi_o,
  output logic                      rw_o,
  output logic                      wr_stb_o,
  output logic                      wr_first_o,
  output logic [SEL_BITS+HI_BITS:0] wr_byte_o,
  output logic                      rd_take_o,
  output logic                      stop_stb_o
);

  twsm_line_t ev;

  twsm_line_mon #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_line (
    .clk  (clk),
    .rst  (rst),
    .scl_i(scl_i),
    .sda_i(sda_i),
    .ev_o (ev)
  );

  twsm_engine #(
    .SEL_BITS    (SEL_BITS),
    .HI_BITS     (HI_BITS),
    .SEL_INV_MASK(SEL_INV_MASK)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .ev         (ev),
    .dev_sel_i  (dev_sel_i),
    .busy_i     (busy_i),
    .rd_data_i  (rd_data_i),
    .sda_drv_n_o(sda_drv_n_o),
    .addr_stb_o (addr_stb_o),
    .addr_hi_o  (addr_hi_o),
    .rw_o       (rw_o),
    .wr_stb_o   (wr_stb_o),
    .wr_first_o (wr_first_o),
    .wr_byte_o  (wr_byte_o),
    .rd_take_o  (rd_take_o),
    .stop_stb_o (stop_stb_o)
  );

endmodule

// File: rtl/twsm_slave_chk.sv
`timescale 1ns/1ps
module twsm_slave_chk (
  input logic clk,
  input logic rst,
  input logic busy_i,
  input logic sda_drv_n_o,
  input logic addr_stb_o,
  input logic wr_stb_o,
  input logic rd_take_o,
  input logic stop_stb_o
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (sda_drv_n_o && !addr_stb_o && !wr_stb_o && !rd_take_o && !stop_stb_o));

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({addr_stb_o, wr_stb_o, rd_take_o, stop_stb_o}));

  a_r4_addr_ack_drive: assert property (@(posedge clk) disable iff (rst)
    addr_stb_o |-> !sda_drv_n_o);

  a_r5_busy_no_accept: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> !addr_stb_o);

  a_r6_byte_ack_drive: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> !sda_drv_n_o);

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_stb_o |-> sda_drv_n_o);

endmodule

bind twsm_slave twsm_slave_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy_i     (busy_i),
  .sda_drv_n_o(sda_drv_n_o),
  .addr_stb_o (addr_stb_o),
  .wr_stb_o   (wr_stb_o),
  .rd_take_o  (rd_take_o),
  .stop_stb_o (stop_stb_o)
);

// File: tb/twsm_slave_bench.sv
`timescale 1ns/1ps
module twsm_slave_bench;

  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] dev_sel = 3'b010;
  logic       busy = 1'b0;
  logic [7:0] rd_data;
  logic       sda_line;

  logic       sda_drv_n, addr_stb, rw, wr_stb, wr_first, rd_take, stop_stb;
  logic [3:0] addr_hi;
  logic [7:0] wr_byte;

  int n_chk = 0, n_err = 0;
  int n_addr = 0, n_wr = 0, n_take = 0, n_stop = 0, rd_ptr = 0;
  logic [7:0] last_wr = '0;
  logic       last_first = 1'b0, last_rw = 1'b0;
  logic [3:0] last_hi = '0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  // open-drain wire with pull-up
  assign sda_line = sda_m & sda_drv_n;

  function automatic logic [7:0] rd_model(int p);
    return 8'((p * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] addr_byte(logic [2:0] pins, logic [3:0] hi, logic r);
    return {~pins[2], pins[1], ~pins[0], hi, r};
  endfunction

  assign rd_data = rd_model(rd_ptr);

  twsm_slave u_twsm_slave (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .dev_sel_i  (dev_sel),
    .busy_i     (busy),
    .rd_data_i  (rd_data),
    .sda_drv_n_o(sda_drv_n),
    .addr_stb_o (addr_stb),
    .addr_hi_o  (addr_hi),
    .rw_o       (rw),
    .wr_stb_o   (wr_stb),
    .wr_first_o (wr_first),
    .wr_byte_o  (wr_byte),
    .rd_take_o  (rd_take),
    .stop_stb_o (stop_stb)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (addr_stb) begin n_addr++; last_hi = addr_hi; last_rw = rw; end
      if (wr_stb)   begin n_wr++; last_wr = wr_byte; last_first = wr_first; end
      if (rd_take)  begin n_take++; rd_ptr++; end
      if (stop_stb) n_stop++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(2*Q);
    sda_m = 1'b0; wt(2*Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(2*Q);
    sda_m = 1'b1; wt(2*Q);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b;    wt(Q);
    scl_m = 1'b1; wt(Q);
    seen = sda_line;
    wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(!ack, s);
  endtask

  // Full write: address, n bytes, stop; all checks inside
  task automatic do_write(input logic [3:0] hi, input int n);
    logic ack;
    logic [7:0] d;
    int a0, w0, s0;
    a0 = n_addr; s0 = n_stop;
    bus_start();
    send_byte(addr_byte(dev_sel, hi, 1'b0), ack);
    chk(ack, "R4 address ack", int'(ack), 1);
    chk(n_addr == a0 + 1, "R4 address strobe", n_addr, a0 + 1);
    chk(last_hi == hi && !last_rw, "R3 upper bits and direction", int'(last_hi), int'(hi));
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      w0 = n_wr;
      send_byte(d, ack);
      chk(ack, "R6 byte ack", int'(ack), 1);
      chk(n_wr == w0 + 1 && last_wr == d, "R6 byte value", int'(last_wr), int'(d));
      chk(last_first == (k == 0), "R6 first flag", int'(last_first), int'(k == 0));
    end
    bus_stop();
    chk(n_stop == s0 + 1, "R2 stop strobe after write", n_stop, s0 + 1);
  endtask

  task automatic do_read(input logic [3:0] hi, input int n);
    logic ack;
    logic [7:0] b;
    int base, t0, s0;
    t0 = n_take; s0 = n_stop;
    bus_start();
    send_byte(addr_byte(dev_sel, hi, 1'b1), ack);
    base = rd_ptr;
    chk(ack, "R4 read address ack", int'(ack), 1);
    chk(last_rw == 1'b1 && last_hi == hi, "R3 read direction", int'(last_rw), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk(b == rd_model(base + k), "R7 read byte", int'(b), int'(rd_model(base + k)));
    end
    chk(n_take == t0 + n, "R7 take count", n_take, t0 + n);
    bus_stop();
    chk(n_stop == s0, "R8 no stop strobe after nack", n_stop, s0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic ack, s;
    logic [7:0] b;
    int a0, w0, s0, t0;
    void'($urandom(32'd4242));

    wt(6);
    chk(sda_drv_n && !addr_stb && !wr_stb && !rd_take && !stop_stb,
        "R1 reset state", int'(sda_drv_n), 1);
    rst = 1'b0;
    wt(10);
    chk(sda_drv_n, "R1 released after reset", int'(sda_drv_n), 1);

    // directed write and read
    do_write(4'hA, 4);
    do_read(4'h3, 3);

    // R8: after master nack the line stays released and bytes are ignored
    bus_start();
    send_byte(addr_byte(dev_sel, 4'h1, 1'b1), ack);
    recv_byte(1'b0, b);
    clk_bit(1'b1, s);
    chk(s == 1'b1, "R8 released after nack", int'(s), 1);
    w0 = n_wr;
    send_byte(8'h00, ack);
    chk(!ack && n_wr == w0, "R8 ignored after nack", int'(ack), 0);
    bus_stop();

    // R9: mismatched S1 bit
    a0 = n_addr; w0 = n_wr; s0 = n_stop;
    bus_start();
    send_byte(addr_byte(dev_sel, 4'h5, 1'b0) ^ 8'h40, ack);
    chk(!ack && n_addr == a0, "R9 no ack on mismatch", int'(ack), 0);
    send_byte(8'h00, ack);
    chk(!ack && n_wr == w0, "R9 bytes ignored", n_wr, w0);
    bus_stop();
    chk(n_stop == s0, "R9 no stop strobe", n_stop, s0);
    // mismatched S0 bit when sent uninverted
    bus_start();
    send_byte(addr_byte(dev_sel, 4'h5, 1'b0) ^ 8'h20, ack);
    chk(!ack, "R3 S0 must be inverted", int'(ack), 0);
    bus_stop();

    // R5: busy blocks address acceptance
    busy = 1'b1; wt(4);
    a0 = n_addr;
    bus_start();
    send_byte(addr_byte(dev_sel, 4'h2, 1'b0), ack);
    chk(!ack && n_addr == a0, "R5 no ack while busy", int'(ack), 0);
    bus_stop();
    busy = 1'b0; wt(4);

    // R10: stop inside the address byte, then clocks without start
    a0 = n_addr; s0 = n_stop;
    bus_start();
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    bus_stop();
    chk(n_stop == s0, "R10 no stop strobe from address abort", n_stop, s0);
    send_byte(addr_byte(dev_sel, 4'h2, 1'b0), ack);
    chk(!ack && n_addr == a0, "R10 idle after abort", int'(ack), 0);
    bus_stop();

    // R10: stop inside a data byte drops the partial byte
    bus_start();
    send_byte(addr_byte(dev_sel, 4'h7, 1'b0), ack);
    send_byte(8'h3C, ack);
    w0 = n_wr; s0 = n_stop;
    for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
    bus_stop();
    chk(n_wr == w0, "R10 partial byte dropped", n_wr, w0);
    chk(n_stop == s0 + 1, "R2 stop during write", n_stop, s0 + 1);

    // R10: start inside a byte restarts the address phase
    a0 = n_addr;
    bus_start();
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    bus_start();
    send_byte(addr_byte(dev_sel, 4'h9, 1'b0), ack);
    chk(ack && n_addr == a0 + 1 && last_hi == 4'h9, "R10 restart accepted", int'(ack), 1);
    bus_stop();

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [3:0] hi;
      logic r, match;
      int n;
      dev_sel = 3'($urandom);
      hi = 4'($urandom);
      r = 1'($urandom);
      match = ($urandom % 4) != 0;
      n = 1 + int'($urandom % 4);
      wt(4);
      if (match) begin
        if (r) do_read(hi, n);
        else   do_write(hi, n);
      end else begin
        a0 = n_addr; s0 = n_stop; t0 = n_take;
        bus_start();
        send_byte(addr_byte(dev_sel, hi, r) ^ (8'h20 << ($urandom % 3)), ack);
        chk(!ack && n_addr == a0, "R9 random mismatch", int'(ack), 0);
        bus_stop();
        chk(n_stop == s0 && n_take == t0, "R9 random silent", n_stop, s0);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule